// File: doc/BRIEF.md
# Network-Synchronised CPU Wait Generator

This block stalls the processor on a shared network line. A CPU I/O write to a fixed control port, with data bit 5 cleared, arms a wait request. From the first falling clock edge after that write is seen, the block drives the active-low WAIT output. This stalls the triggering write cycle itself. WAIT stays asserted for as long as the external NET line is high. Network software uses this to line itself up with traffic on the wire.

Once NET goes low, WAIT is released after a fixed number of falling CPU clock edges. That count includes a two-stage synchroniser on NET. There is no timeout. If the local node is itself holding NET high when it triggers the wait, the processor stays stalled until reset. Every register in the block is clocked on the falling edge of the CPU clock.

Top module: `net_wait_gen`

## Requirements
- R1: A trigger is a cycle with `iorq_n`=0, `wr_n`=0, `addr`=0xEF and `data` bit 5 = 0, sampled on a falling clock edge.
- R2: `wait_n` goes low on the first falling edge at which the trigger is sampled, and the write cycle is still in progress at that point.
- R3: None of these ever drives `wait_n` low: writes to 0xEF with data bit 5 = 1, writes to any other address, and reads (`wr_n`=1).
- R4: While NET stays high, `wait_n` stays low indefinitely. There is no timeout.
- R5: When NET goes low between two falling edges and stays low, `wait_n` returns high on the fourth falling edge counted from the first edge that samples NET low.
- R6: If NET is already low (and synchronised) when the trigger is sampled, `wait_n` returns high on the second falling edge after the edge that asserted it.
- R7: A NET low pulse that only one falling edge samples does not release WAIT. The release count restarts, and a later steady low again takes four edges.
- R8: A write cycle triggers only once. After release, `wait_n` stays high while `iorq_n` and `wr_n` remain low.
- R9: An active-low asynchronous reset drives `wait_n` high at once and clears the armed state. After reset, NET high alone does not assert WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all registers act on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iorq_n | input | 1 | Active-low I/O request |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 8 | Low byte of the I/O address |
| data | input | 8 | CPU data bus during the write |
| net | input | 1 | Shared network line, active high, asynchronous |
| wait_n | output | 1 | Active-low CPU wait request |

## Verification
The bench measures how long WAIT is held, in falling edges, after NET drops. It also measures the delay when NET is already low at trigger time. A design that counted from the raw line rather than the synchronised one would release one or two edges early. A design that dropped the count would release at once.

A single-edge NET dip is applied to catch a counter that does not restart. A held write cycle is kept low past the release to catch a block that re-arms on the same write and locks the CPU. A long NET-high hold catches any hidden timeout. Writes with bit 5 set, writes to a neighbouring address, and reads are applied to expose a loose decode.

// File: rtl/net_wait_gen.sv
module net_wait_gen #(
  parameter int ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hEF,
  parameter int DATA_W        = 8,
  parameter int HOLD_BIT      = 5,
  parameter int RELEASE_EDGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              net,
  output logic              wait_n
);

  localparam int CNT_W = (RELEASE_EDGES > 3) ? $clog2(RELEASE_EDGES) : 1;
  localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(RELEASE_EDGES - 3);

  logic             net_s1, net_s2;
  logic             armed, cyc_seen;
  logic [CNT_W-1:0] quiet_cnt;

  wire io_wr       = !iorq_n && !wr_n && (addr == PORT_ADDR);
  wire trigger     = io_wr && !data[HOLD_BIT] && !cyc_seen && !armed;
  wire release_now = armed && !net_s2 && (quiet_cnt == QUIET_LAST);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      net_s1    <= 1'b0;
      net_s2    <= 1'b0;
      armed     <= 1'b0;
      cyc_seen  <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      net_s1   <= net;
      net_s2   <= net_s1;
      cyc_seen <= io_wr && (cyc_seen || trigger);
      if (trigger) begin
        armed     <= 1'b1;
        quiet_cnt <= '0;
      end else if (release_now) begin
        armed     <= 1'b0;
        quiet_cnt <= '0;
      end else if (armed) begin
        quiet_cnt <= net_s2 ? '0 : quiet_cnt + 1'b1;
      end
    end
  end

  assign wait_n = !armed;

  // R2: a sampled trigger pulls WAIT low on that edge
  assert_trigger_asserts_R2: assert property (@(negedge clk) disable iff (!rst_n)
    (!iorq_n && !wr_n && addr == PORT_ADDR && !data[HOLD_BIT] && wait_n && !cyc_seen)
    |=> !wait_n);

  // R3: bit 5 set never starts a wait from idle
  assert_d5_set_idle_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (wait_n && data[HOLD_BIT]) |=> wait_n);

  // R4: synchronised NET high keeps the CPU stalled
  assert_hold_on_net_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (!wait_n && net_s2) |=> !wait_n);

  // R5: a release only follows a quiet synchronised line
  assert_release_quiet_R5: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(wait_n) |-> !$past(net_s2));

  // R7: the quiet counter never passes its terminal value
  assert_cnt_bound_R7: assert property (@(negedge clk) disable iff (!rst_n)
    quiet_cnt <= QUIET_LAST);

  // R8: no re-arm while the same write cycle is still held
  assert_single_shot_R8: assert property (@(negedge clk) disable iff (!rst_n)
    ($rose(wait_n) && !iorq_n && !wr_n) |=> wait_n);

endmodule

// File: tb/net_wait_gen_tb_top.sv
module net_wait_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iorq_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] data = 8'h00;
  logic       net = 1'b0;
  logic       wait_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  net_wait_gen dut_i (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .wr_n(wr_n),
    .addr(addr), .data(data), .net(net), .wait_n(wait_n)
  );

  // {addr, data, net_at_trigger, hold, expect_assert, expect_release_edges}
  localparam logic [29:0] VEC [7] = '{
    {8'hEF, 8'h00, 1'b1, 8'd3,  1'b1, 4'd4},
    {8'hEF, 8'hDF, 1'b1, 8'd10, 1'b1, 4'd4},
    {8'hEF, 8'h20, 1'b1, 8'd3,  1'b0, 4'd0},
    {8'hEE, 8'h00, 1'b1, 8'd3,  1'b0, 4'd0},
    {8'hEF, 8'h00, 1'b0, 8'd0,  1'b1, 4'd2},
    {8'hEF, 8'hFF, 1'b0, 8'd0,  1'b0, 4'd0},
    {8'hEF, 8'h5A, 1'b1, 8'd6,  1'b1, 4'd4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_release(output int n);
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (wait_n == 1'b0 && n < 40);
  endtask

  task automatic end_cycle();
    @(posedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; net = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic issue_write(input logic [7:0] a, input logic [7:0] d, input logic rd);
    @(posedge clk);
    addr = a; data = d; iorq_n = 1'b0; wr_n = rd;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1 check("R9 reset state", wait_n, 1);
    @(posedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 7; i++) begin
      logic [7:0] va, vd, vh;
      logic vnet, vexp;
      logic [3:0] vrel;
      {va, vd, vnet, vh, vexp, vrel} = VEC[i];
      @(posedge clk); net = vnet;
      repeat (3) @(posedge clk);
      issue_write(va, vd, 1'b0);
      @(negedge clk); #1;
      check(vexp ? "R1 R2 assert on first edge" : "R3 no assert", wait_n, !vexp);
      if (vexp) begin
        if (vnet) begin
          repeat (int'(vh)) @(posedge clk);
          check("R4 held while NET high", wait_n, 0);
          @(posedge clk); net = 1'b0;
        end
        count_release(n);
        check(vnet ? "R5 release edges" : "R6 release edges", n, vrel);
        repeat (2) begin
          @(negedge clk); #1;
          check("R8 no retrigger in held cycle", wait_n, 1);
        end
      end else begin
        repeat (3) @(negedge clk);
        #1 check("R3 stays released", wait_n, 1);
      end
      end_cycle();
    end

    // R3: read cycle to the port
    @(posedge clk); net = 1'b1;
    issue_write(8'hEF, 8'h00, 1'b1);
    repeat (3) @(negedge clk);
    #1 check("R3 read ignored", wait_n, 1);
    end_cycle();

    // R4: long hold, no timeout
    @(posedge clk); net = 1'b1;
    repeat (3) @(posedge clk);
    issue_write(8'hEF, 8'h00, 1'b0);
    repeat (300) @(negedge clk);
    #1 check("R4 no timeout", wait_n, 0);
    @(posedge clk); net = 1'b0;
    count_release(n);
    check("R5 release after long hold", n, 4);
    end_cycle();

    // R7: single-edge dip
    @(posedge clk); net = 1'b1;
    repeat (3) @(posedge clk);
    issue_write(8'hEF, 8'h00, 1'b0);
    repeat (3) @(posedge clk);
    net = 1'b0;
    @(posedge clk); net = 1'b1;
    repeat (6) @(negedge clk);
    #1 check("R7 dip does not release", wait_n, 0);
    @(posedge clk); net = 1'b0;
    count_release(n);
    check("R7 full count after dip", n, 4);
    end_cycle();

    // R9: reset during a wait
    @(posedge clk); net = 1'b1;
    repeat (3) @(posedge clk);
    issue_write(8'hEF, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    #1 check("R9 armed before reset", wait_n, 0);
    @(posedge clk); rst_n = 1'b0; iorq_n = 1'b1; wr_n = 1'b1;
    #1 check("R9 async release", wait_n, 1);
    @(posedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R9 NET alone does not arm", wait_n, 1);
    end_cycle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule